// File: doc/BRIEF.md
# Output Protection and Power-Good Supervisor

This block watches a set of digital comparator flags that describe where a regulator output sits relative to its set point. The flags say whether the output is above 125% of target, below the 90% window edge, below 70% of target, or above 93% of target. A soft-start-done flag, a phase-above-1V flag, a set-point-change strobe and the enable input also feed the block. From these it produces a filtered power-good signal, a latched over-voltage fault and a latched under-voltage fault. The two faults drive an override output set that takes priority over the PWM gate commands downstream.

An over-voltage fault holds the low-side switch on to discharge the output. An under-voltage fault turns both switches off. While the under-voltage fault is active, the low-side switch is pulsed on whenever the switch node is still above 1 V. Each qualifier uses a consecutive-cycle timer that starts again from zero when its condition drops out. After a set-point change, power-good is frozen and fault detection is suspended for a fixed number of cycles, so the output can move to its new level without a false trip. Dropping `en` or asserting `rst_n` low clears all state.

Top module: `vout_guard`

## Requirements
- R1: With `rst_n` low, or with `en` low at a clock edge, `pgood`, `ov_fault`, `uv_fault`, `ovr_en` and `ovr_ls` are 0 after that edge.
- R2: While `ss_done` is 0 and no mask is active, `pgood` is 0 after every clock edge, whatever the output flags say.
- R3: `pgood` first rises only after `rdy_flag` (output above 93%) has been seen with `ss_done` high. It then rises on the PG_DLY-th consecutive edge at which the good condition holds (`ss_done` high, `over_flag` 0, `low_flag` 0).
- R4: A high `pgood` falls on the PG_DLY-th consecutive edge with `over_flag` or `low_flag` set. It rises again after PG_DLY in-window edges without needing `rdy_flag` again, until `en` drops.
- R5: A power-good excursion shorter than PG_DLY edges leaves `pgood` unchanged, and the count restarts from zero.
- R6: `ov_fault` sets on the OV_DLY-th consecutive unmasked edge with `over_flag` high. A gap of even one edge restarts the count.
- R7: `ov_fault` stays set after `over_flag` clears, and only `en` low or `rst_n` low clears it. While it is set, `ovr_en`=1, `ovr_hs`=0 and `ovr_ls`=1.
- R8: `uv_fault` sets on the UV_DLY-th consecutive unmasked edge with `uv_flag` high and stays set until `en` or `rst_n` is low. While it is set without `ov_fault`, `ovr_en`=1 and `ovr_hs`=0.
- R9: While `uv_fault` is set and `ov_fault` is clear, `ovr_ls` equals `phase_hi` in the same cycle, with no register delay.
- R10: A `sp_change` pulse sampled at a clock edge masks the MASK_CYC edges that follow it. During the mask, `pgood` holds its value and the fault timers stay at zero, so counting restarts on the first unmasked edge.
- R11: Whenever either fault is set and no mask is active, `pgood` is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| en | input | 1 | Enable; low clears all state |
| ss_done | input | 1 | Soft-start finished |
| sp_change | input | 1 | Set-point change strobe |
| over_flag | input | 1 | Output above 125% of target |
| low_flag | input | 1 | Output below 90% of target |
| uv_flag | input | 1 | Output below 70% of target |
| rdy_flag | input | 1 | Output above 93% of target |
| phase_hi | input | 1 | Switch node above 1 V |
| pgood | output | 1 | Power-good, active high |
| ov_fault | output | 1 | Latched over-voltage fault |
| uv_fault | output | 1 | Latched under-voltage fault |
| ovr_en | output | 1 | Override of PWM gate commands active |
| ovr_hs | output | 1 | High-side gate value under override |
| ovr_ls | output | 1 | Low-side gate value under override |

## Verification
Registered results follow a fixed count of edges. `pgood` moves on the PG_DLY-th qualifying edge. `ov_fault` and `uv_fault` set on the OV_DLY-th and UV_DLY-th qualifying edges. The mask covers exactly MASK_CYC edges after the strobe edge. The bench changes inputs on the falling edge, waits exactly that many rising edges, and samples on the next falling edge, so each check lands on the first cycle where the new value is due. It also checks one edge earlier to show nothing moves too soon. The `ovr_ls` discharge path is combinational, so it is checked one time unit after `phase_hi` changes, with no clock edge in between.

// File: rtl/vout_guard.sv
module vout_guard #(
  parameter int PG_DLY   = 312,
  parameter int OV_DLY   = 2500,
  parameter int UV_DLY   = 312,
  parameter int MASK_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ss_done,
  input  logic sp_change,
  input  logic over_flag,
  input  logic low_flag,
  input  logic uv_flag,
  input  logic rdy_flag,
  input  logic phase_hi,
  output logic pgood,
  output logic ov_fault,
  output logic uv_fault,
  output logic ovr_en,
  output logic ovr_hs,
  output logic ovr_ls
);
  localparam int PW = $clog2(PG_DLY + 1);
  localparam int OW = $clog2(OV_DLY + 1);
  localparam int UW = $clog2(UV_DLY + 1);
  localparam int MW = $clog2(MASK_CYC + 1);

  logic [PW-1:0] pg_cnt;
  logic [OW-1:0] ov_cnt;
  logic [UW-1:0] uv_cnt;
  logic [MW-1:0] mask_q;
  logic          seen_rdy;
  logic          masked;
  logic          pg_cond;

  assign masked  = sp_change | (mask_q != '0);
  assign pg_cond = ss_done & (seen_rdy | rdy_flag) & ~over_flag & ~low_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (!en)       mask_q <= '0;
    else if (sp_change) mask_q <= MW'(MASK_CYC);
    else if (mask_q != '0) mask_q <= mask_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_fault <= 1'b0;
      ov_cnt   <= '0;
    end else if (!en) begin
      ov_fault <= 1'b0;
      ov_cnt   <= '0;
    end else if (masked || !over_flag || ov_fault) begin
      ov_cnt <= '0;
    end else if (ov_cnt == OW'(OV_DLY - 1)) begin
      ov_fault <= 1'b1;
      ov_cnt   <= '0;
    end else begin
      ov_cnt <= ov_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_fault <= 1'b0;
      uv_cnt   <= '0;
    end else if (!en) begin
      uv_fault <= 1'b0;
      uv_cnt   <= '0;
    end else if (masked || !uv_flag || uv_fault) begin
      uv_cnt <= '0;
    end else if (uv_cnt == UW'(UV_DLY - 1)) begin
      uv_fault <= 1'b1;
      uv_cnt   <= '0;
    end else begin
      uv_cnt <= uv_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   seen_rdy <= 1'b0;
    else if (!en)                 seen_rdy <= 1'b0;
    else if (ss_done && rdy_flag) seen_rdy <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgood  <= 1'b0;
      pg_cnt <= '0;
    end else if (!en) begin
      pgood  <= 1'b0;
      pg_cnt <= '0;
    end else if (masked) begin
      pg_cnt <= '0;
    end else if (ov_fault || uv_fault || !ss_done) begin
      pgood  <= 1'b0;
      pg_cnt <= '0;
    end else if (pg_cond == pgood) begin
      pg_cnt <= '0;
    end else if (pg_cnt == PW'(PG_DLY - 1)) begin
      pgood  <= pg_cond;
      pg_cnt <= '0;
    end else begin
      pg_cnt <= pg_cnt + 1'b1;
    end
  end

  assign ovr_en = ov_fault | uv_fault;
  assign ovr_hs = 1'b0;
  assign ovr_ls = ov_fault | (uv_fault & phase_hi);

  a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pgood && !ov_fault && !uv_fault && !ovr_en));

  a_r2_softstart_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ss_done && !masked) |=> !pgood);

  a_r6_ov_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_fault) |-> $past(over_flag));

  a_r7_ov_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_fault && en) |=> ov_fault);

  a_r8_uv_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_fault && en) |=> uv_fault);

  a_r10_pg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mask_q != '0) |=> $stable(pgood));

  a_r11_fault_kills_pg: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (ov_fault || uv_fault) && !masked) |=> !pgood);
endmodule

// File: tb/vout_guard_bench.sv
module vout_guard_bench;
  localparam int PG = 8;
  localparam int OV = 20;
  localparam int UV = 6;
  localparam int MK = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ss_done = 1'b0, sp_change = 1'b0;
  logic over_flag = 1'b0, low_flag = 1'b0, uv_flag = 1'b0, rdy_flag = 1'b0, phase_hi = 1'b0;
  logic pgood, ov_fault, uv_fault, ovr_en, ovr_hs, ovr_ls;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vout_guard #(.PG_DLY(PG), .OV_DLY(OV), .UV_DLY(UV), .MASK_CYC(MK)) u_vout_guard (
    .clk(clk), .rst_n(rst_n), .en(en), .ss_done(ss_done), .sp_change(sp_change),
    .over_flag(over_flag), .low_flag(low_flag), .uv_flag(uv_flag), .rdy_flag(rdy_flag),
    .phase_hi(phase_hi), .pgood(pgood), .ov_fault(ov_fault), .uv_fault(uv_fault),
    .ovr_en(ovr_en), .ovr_hs(ovr_hs), .ovr_ls(ovr_ls));

  // {ss, rdy, low, over, uv} , edges , {pgood, ov_fault, uv_fault, ovr_ls}
  localparam logic [16:0] VEC [13] = '{
    {5'b01000, 8'd10, 4'b0000},
    {5'b10100, 8'd10, 4'b0000},
    {5'b11000, 8'd7,  4'b0000},
    {5'b11000, 8'd1,  4'b1000},
    {5'b11100, 8'd7,  4'b1000},
    {5'b11000, 8'd3,  4'b1000},
    {5'b11100, 8'd8,  4'b0000},
    {5'b10000, 8'd8,  4'b1000},
    {5'b11010, 8'd19, 4'b0000},
    {5'b11000, 8'd1,  4'b0000},
    {5'b11010, 8'd19, 4'b0000},
    {5'b11010, 8'd1,  4'b0101},
    {5'b11000, 8'd20, 4'b0101}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R2";
      1, 2, 3: return "R3";
      4, 5: return "R5";
      6, 7: return "R4";
      8, 9, 10: return "R6";
      11: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_flags(logic s, logic r, logic l, logic o, logic u);
    ss_done = s; rdy_flag = r; low_flag = l; over_flag = o; uv_flag = u;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    step(3);
    chk("R1", "pgood in reset", pgood, 1'b0);
    chk("R1", "ov_fault in reset", ov_fault, 1'b0);
    chk("R1", "ovr_en in reset", ovr_en, 1'b0);
    rst_n = 1'b1;
    en = 1'b1;
    step(2);

    for (int i = 0; i < 13; i++) begin
      set_flags(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12]);
      step(int'(VEC[i][11:4]));
      chk(vec_tag(i), "pgood", pgood, VEC[i][3]);
      chk(vec_tag(i), "ov_fault", ov_fault, VEC[i][2]);
      chk(vec_tag(i), "uv_fault", uv_fault, VEC[i][1]);
      chk(vec_tag(i), "ovr_ls", ovr_ls, VEC[i][0]);
    end
    chk("R7", "ovr_en during ov", ovr_en, 1'b1);
    chk("R7", "ovr_hs during ov", ovr_hs, 1'b0);

    en = 1'b0;
    step(1);
    chk("R7", "ov_fault after enable low", ov_fault, 1'b0);
    chk("R1", "ovr_en after enable low", ovr_en, 1'b0);
    en = 1'b1;

    set_flags(1, 1, 1, 0, 1);
    step(UV - 1);
    chk("R8", "uv_fault early", uv_fault, 1'b0);
    step(1);
    chk("R8", "uv_fault set", uv_fault, 1'b1);
    chk("R8", "ovr_en uv", ovr_en, 1'b1);
    chk("R8", "ovr_hs uv", ovr_hs, 1'b0);
    chk("R9", "ovr_ls phase low", ovr_ls, 1'b0);
    chk("R11", "pgood with uv", pgood, 1'b0);
    phase_hi = 1'b1;
    #1;
    chk("R9", "ovr_ls phase high", ovr_ls, 1'b1);
    phase_hi = 1'b0;
    #1;
    chk("R9", "ovr_ls phase back low", ovr_ls, 1'b0);
    set_flags(1, 1, 0, 0, 0);
    step(3);
    chk("R8", "uv_fault latched", uv_fault, 1'b1);
    en = 1'b0;
    step(1);
    chk("R8", "uv_fault cleared by enable", uv_fault, 1'b0);
    en = 1'b1;

    set_flags(1, 1, 0, 1, 0);
    step(OV);
    chk("R6", "ov_fault again", ov_fault, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R7", "ov_fault cleared by reset", ov_fault, 1'b0);
    step(1);
    rst_n = 1'b1;

    set_flags(1, 1, 0, 0, 0);
    step(PG);
    chk("R3", "pgood before mask", pgood, 1'b1);
    sp_change = 1'b1;
    step(1);
    sp_change = 1'b0;
    set_flags(1, 1, 1, 1, 0);
    step(MK);
    chk("R10", "pgood frozen", pgood, 1'b1);
    chk("R10", "ov masked", ov_fault, 1'b0);
    step(PG - 1);
    chk("R10", "pgood one before fall", pgood, 1'b1);
    step(1);
    chk("R10", "pgood falls after mask", pgood, 1'b0);
    step(OV - PG - 1);
    chk("R10", "ov one before set", ov_fault, 1'b0);
    step(1);
    chk("R10", "ov sets after mask", ov_fault, 1'b1);

    finish_run();
  end
endmodule